// File: doc/BRIEF.md
# Backplane Waveform Table Sequencer

This block plays a stored waveform table onto a backplane bus, one word at a time. A start pulse gives it the base address of a table in an attached table memory, which is read combinationally. The word at the base address is a length header: its low address-width bits hold the number of waveform words that follow, minus one. Each waveform word is 24 bits wide. Bits 15 to 12 name the destination board and bits 11 to 0 are the payload. Bits 22 to 16 give a hold delay, and bit 23 picks its unit: 1 cycle (40 ns at the intended 25 MHz clock) or 16 cycles.

For an ordinary word, the block places the board number and payload on the bus and raises a write strobe for one cycle. Board number 15 is reserved and never reaches the bus. A word addressed to it loads a local register pair with the first converter channel (payload bits 5 to 0) and the last converter channel (payload bits 10 to 6) of a pixel-transmit sequence. Every word occupies one base cycle plus its hold. A busy flag covers the whole run and a one-cycle done pulse closes it.

Top module: `wave_table_player`

## Requirements
- R1: After reset, busy, done and the write strobe are low, and the board number, payload, first-channel and last-channel outputs are zero.
- R2: With a header whose low 8 bits hold N, exactly N+1 words following the header are played. Words beyond them are not touched.
- R3: A word with bit 23 clear and a delay field D lasts 1+D cycles. For a one-word table, done is seen 2+D cycles after the cycle in which start was sampled.
- R4: A word with bit 23 set and a delay field D lasts 1+16·D cycles. A coarse word with D=0 lasts a single cycle.
- R5: Each word whose bits 15:12 are not 15 raises the write strobe for exactly one cycle. In that cycle, bp_board carries bits 15:12 and bp_data carries bits 11:0. Strobes of consecutive words are spaced by the duration of the earlier word.
- R6: A word whose bits 15:12 are 15 raises no strobe and leaves bp_board and bp_data unchanged. It sets px_first to bits 5:0 and px_last to bits 10:6. These two outputs change only while busy.
- R7: Busy rises the cycle after an accepted start and stays high until the last word's hold expires. Done is high for exactly one cycle, the first cycle with busy low. The total run is 1 plus the sum of the word durations, counted from the start cycle.
- R8: A start that arrives while busy is ignored. The running table keeps its timing and no other table is played.
- R9: A start presented in the cycle in which done is high is accepted and begins a new table.
- R10: When the last word has a zero hold and is a bus word, its strobe and done are high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is the 40 ns base slot |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request to play the table at base_addr |
| base_addr | input | ADDR_W | Address of the table header |
| tbl_addr | output | ADDR_W | Table memory read address |
| tbl_word | input | 24 | Table memory read data for tbl_addr, same cycle |
| bp_board | output | 4 | Destination board number on the backplane |
| bp_data | output | 12 | Payload on the backplane |
| bp_wr | output | 1 | One-cycle backplane write strobe |
| px_first | output | 6 | First converter channel of the transmit sequence |
| px_last | output | 5 | Last converter channel of the transmit sequence |
| busy | output | 1 | A table is being played |
| done | output | 1 | One-cycle pulse at the end of a table |

## Verification
Two events can share a cycle here. The end of one run, marked by the done pulse, can meet a new start. The strobe of a final zero-hold word can also coincide with done. The bench pulses start in the very cycle it sees done and then checks that a second table runs, with its own board, payload and duration. It also builds a four-word table whose last word has no hold and checks that the final strobe and done appear in the same sampled cycle.

// File: rtl/wfseq_pkg.sv
// Shared field widths, word layout and state encoding for the waveform
// table sequencer. Assumes 24-bit table words.
package wfseq_pkg;
    localparam int WORD_W  = 24;
    localparam int DLY_W   = 7;
    localparam int BOARD_W = 4;
    localparam int DATA_W  = 12;
    localparam int FIRST_W = 6;
    localparam int LAST_W  = 5;
    localparam logic [BOARD_W-1:0] LOCAL_BOARD = 4'hF;

    // Layout of one waveform word, most significant field first
    typedef struct packed {
        logic               coarse;
        logic [DLY_W-1:0]   dly;
        logic [BOARD_W-1:0] board;
        logic [DATA_W-1:0]  data;
    } wf_word_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_LEN  = 2'd1,
        S_WORD = 2'd2,
        S_HOLD = 2'd3
    } seq_state_t;
endpackage

// File: rtl/wfseq_decode.sv
// Splits a waveform word into its destination, payload and hold length in
// clock cycles. Purely combinational; assumes HOLD_W = DLY_W + COARSE_SHIFT.
module wfseq_decode
    import wfseq_pkg::*;
#(
    parameter int COARSE_SHIFT = 4,
    parameter int HOLD_W       = DLY_W + COARSE_SHIFT
) (
    input  logic [WORD_W-1:0]  word_in,
    output logic [HOLD_W-1:0]  hold,
    output logic [BOARD_W-1:0] board,
    output logic [DATA_W-1:0]  data,
    output logic               is_local
);
    wf_word_t w;

    // Field split and hold scaling by the selected unit
    always_comb begin
        w        = wf_word_t'(word_in);
        board    = w.board;
        data     = w.data;
        is_local = (w.board == LOCAL_BOARD);
        if (w.coarse)
            hold = HOLD_W'({w.dly, {COARSE_SHIFT{1'b0}}});
        else
            hold = HOLD_W'(w.dly);
    end
endmodule

// File: rtl/wfseq_hold_timer.sv
// Down-counter that times the hold of one word. Loaded with the hold length
// in the word's first cycle; 'last' marks the final hold cycle.
// Assumes load_val is nonzero whenever load is asserted.
module wfseq_hold_timer #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt;

    // Load or count down towards zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    // Final cycle of the hold
    assign last = (cnt == W'(1));
endmodule

// File: rtl/wfseq_pix_range.sv
// Local register pair holding the first and last converter channel of the
// pixel-transmit sequence, written from a reserved-board payload.
module wfseq_pix_range
    import wfseq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [DATA_W-1:0]  payload,
    output logic [FIRST_W-1:0] first_ch,
    output logic [LAST_W-1:0]  last_ch
);
    // Capture both channel fields on a local write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_ch <= '0;
            last_ch  <= '0;
        end else if (wr_en) begin
            first_ch <= payload[FIRST_W-1:0];
            last_ch  <= payload[FIRST_W +: LAST_W];
        end
    end
endmodule

// File: rtl/wave_table_player.sv
// Waveform table sequencer. On start it reads a length header at base_addr,
// then plays header+1 words: bus words raise a one-cycle write strobe with
// board and payload, reserved-board words load the local channel range.
// Each word lasts one cycle plus its hold. Assumes a combinational table
// read (tbl_word valid for tbl_addr in the same cycle) and ADDR_W <= 24.
module wave_table_player
    import wfseq_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int COARSE_SHIFT = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ADDR_W-1:0]  base_addr,
    output logic [ADDR_W-1:0]  tbl_addr,
    input  logic [WORD_W-1:0]  tbl_word,
    output logic [BOARD_W-1:0] bp_board,
    output logic [DATA_W-1:0]  bp_data,
    output logic               bp_wr,
    output logic [FIRST_W-1:0] px_first,
    output logic [LAST_W-1:0]  px_last,
    output logic               busy,
    output logic               done
);
    localparam int HOLD_W = DLY_W + COARSE_SHIFT;
    localparam int REM_W  = ADDR_W + 1;

    seq_state_t         state;
    logic [ADDR_W-1:0]  ptr;
    logic [REM_W-1:0]   rem;
    logic [HOLD_W-1:0]  hold;
    logic [BOARD_W-1:0] dec_board;
    logic [DATA_W-1:0]  dec_data;
    logic               dec_local;
    logic               tmr_last;
    logic               hold_zero;

    wfseq_decode #(
        .COARSE_SHIFT(COARSE_SHIFT),
        .HOLD_W      (HOLD_W)
    ) u_decode (
        .word_in (tbl_word),
        .hold    (hold),
        .board   (dec_board),
        .data    (dec_data),
        .is_local(dec_local)
    );

    wfseq_hold_timer #(
        .W(HOLD_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state == S_WORD && !hold_zero),
        .load_val(hold),
        .last    (tmr_last)
    );

    wfseq_pix_range u_pix (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (state == S_WORD && dec_local),
        .payload (dec_data),
        .first_ch(px_first),
        .last_ch (px_last)
    );

    // Table address: base while idle, running pointer otherwise
    assign tbl_addr  = (state == S_IDLE) ? base_addr : ptr;
    assign hold_zero = (hold == '0);
    assign busy      = (state != S_IDLE);

    // Sequencing of header, word slots and holds; bus outputs and done
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            ptr      <= '0;
            rem      <= '0;
            bp_board <= '0;
            bp_data  <= '0;
            bp_wr    <= 1'b0;
            done     <= 1'b0;
        end else begin
            bp_wr <= 1'b0;
            done  <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (start) begin
                        ptr   <= base_addr;
                        state <= S_LEN;
                    end
                end
                S_LEN: begin
                    rem   <= {1'b0, tbl_word[ADDR_W-1:0]} + REM_W'(1);
                    ptr   <= ptr + ADDR_W'(1);
                    state <= S_WORD;
                end
                S_WORD: begin
                    ptr <= ptr + ADDR_W'(1);
                    rem <= rem - REM_W'(1);
                    if (!dec_local) begin
                        bp_board <= dec_board;
                        bp_data  <= dec_data;
                        bp_wr    <= 1'b1;
                    end
                    if (!hold_zero) begin
                        state <= S_HOLD;
                    end else if (rem == REM_W'(1)) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end
                end
                S_HOLD: begin
                    if (tmr_last) begin
                        if (rem == '0) begin
                            state <= S_IDLE;
                            done  <= 1'b1;
                        end else begin
                            state <= S_WORD;
                        end
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/wave_table_player_chk.sv
// Protocol checker for the waveform table sequencer, attached by bind.
// Observes ports only.
module wave_table_player_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic        busy,
    input logic        done,
    input logic        bp_wr,
    input logic [3:0]  bp_board,
    input logic [11:0] bp_data,
    input logic [5:0]  px_first,
    input logic [4:0]  px_last
);
    // R5
    strobe_board_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bp_wr |-> bp_board != 4'hF);

    // R6
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bp_wr |-> $stable(bp_board) && $stable(bp_data));

    // R6
    pix_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> $stable(px_first) && $stable(px_last));

    // R7
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7
    busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start |=> busy);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !start |=> !busy && !bp_wr);
endmodule

bind wave_table_player wave_table_player_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .busy    (busy),
    .done    (done),
    .bp_wr   (bp_wr),
    .bp_board(bp_board),
    .bp_data (bp_data),
    .px_first(px_first),
    .px_last (px_last)
);

// File: tb/wave_table_player_test.sv
`timescale 1ns/1ps
// Self-checking bench: vector table of one-word programs, then directed
// tests for reset, multi-word tables and start collisions.
module wave_table_player_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  base_addr = '0;
    logic [7:0]  tbl_addr;
    logic [23:0] tbl_word;
    logic [3:0]  bp_board;
    logic [11:0] bp_data;
    logic        bp_wr;
    logic [5:0]  px_first;
    logic [4:0]  px_last;
    logic        busy;
    logic        done;

    logic [23:0] mem [0:255];
    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    int r_dur, r_nwr, r_lastwr;
    bit r_busyok;

    always #2 clk = ~clk;
    assign tbl_word = mem[tbl_addr];

    wave_table_player uut (
        .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
        .tbl_addr(tbl_addr), .tbl_word(tbl_word), .bp_board(bp_board),
        .bp_data(bp_data), .bp_wr(bp_wr), .px_first(px_first),
        .px_last(px_last), .busy(busy), .done(done)
    );

    typedef struct packed {
        logic [23:0] word;
        logic        wr;
        logic [3:0]  board;
        logic [11:0] data;
        logic [5:0]  first;
        logic [4:0]  last;
        logic [11:0] dur;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{24'h003ABC, 1'b1, 4'h3, 12'hABC, 6'd0, 5'd0, 12'd2},
        '{24'h072555, 1'b1, 4'h2, 12'h555, 6'd0, 5'd0, 12'd9},
        '{24'h8110F0, 1'b1, 4'h1, 12'h0F0, 6'd0, 5'd0, 12'd18},
        '{24'h835123, 1'b1, 4'h5, 12'h123, 6'd0, 5'd0, 12'd50},
        '{24'h02F0C5, 1'b0, 4'h5, 12'h123, 6'd5, 5'd3, 12'd4},
        '{24'h7F0FFF, 1'b1, 4'h0, 12'hFFF, 6'd5, 5'd3, 12'd129},
        '{24'hFFE001, 1'b1, 4'hE, 12'h001, 6'd5, 5'd3, 12'd2034},
        '{24'h809800, 1'b1, 4'h9, 12'h800, 6'd5, 5'd3, 12'd2}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Present start at the current negedge, then follow the run to done
    task automatic launch(input logic [7:0] base);
        base_addr = base;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_dur = 0; r_nwr = 0; r_lastwr = 0; r_busyok = 1'b1;
        for (int c = 1; c <= 3000; c++) begin
            @(negedge clk);
            if (bp_wr) begin r_nwr++; r_lastwr = c; end
            if (done) begin
                r_dur = c;
                if (busy) r_busyok = 1'b0;
                break;
            end
            if (!busy) r_busyok = 1'b0;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 24'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);
        chk("R1 strobe", bp_wr, 0);
        chk("R1 bus", {bp_board, bp_data}, 0);
        chk("R1 channels", {px_first, px_last}, 0);

        // Vector table: one-word programs
        for (int v = 0; v < 8; v++) begin
            mem[0] = 24'h0;
            mem[1] = VECS[v].word;
            @(negedge clk);
            launch(8'h00);
            if (VECS[v].word[23]) chk("R4 coarse duration", r_dur, VECS[v].dur);
            else                  chk("R3 fine duration", r_dur, VECS[v].dur);
            chk("R5 R6 strobe count", r_nwr, VECS[v].wr);
            chk("R5 R6 bus value", {bp_board, bp_data}, {VECS[v].board, VECS[v].data});
            chk("R6 channel range", {px_first, px_last}, {VECS[v].first, VECS[v].last});
            chk("R7 busy through run", r_busyok, 1);
            @(negedge clk);
            chk("R7 done single cycle", done, 0);
        end

        // R2 R10: four-word table, last word zero hold on the bus
        mem[8'h40] = 24'h000003;
        mem[8'h41] = 24'h001111;
        mem[8'h42] = 24'h012222;
        mem[8'h43] = 24'h02F7FF;
        mem[8'h44] = 24'h004444;
        mem[8'h45] = 24'h00D999;
        @(negedge clk);
        launch(8'h40);
        chk("R2 words played", r_nwr, 3);
        chk("R7 multiword duration", r_dur, 8);
        chk("R10 last strobe with done", r_lastwr, 8);
        chk("R2 last bus word", {bp_board, bp_data}, 16'h4444);
        chk("R6 channel range multiword", {px_first, px_last}, {6'h3F, 5'h1F});

        // R8: start while busy is ignored
        mem[8'h60] = 24'h0;
        mem[8'h61] = 24'h835123;
        mem[8'h70] = 24'h0;
        mem[8'h71] = 24'h00C777;
        @(negedge clk);
        base_addr = 8'h60;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        r_dur = 0; r_nwr = 0;
        for (int c = 1; c <= 200; c++) begin
            if (c == 10) begin base_addr = 8'h70; start = 1'b1; end
            if (c == 11) start = 1'b0;
            @(negedge clk);
            if (bp_wr) r_nwr++;
            if (done) begin r_dur = c; break; end
        end
        chk("R8 duration kept", r_dur, 50);
        chk("R8 single strobe", r_nwr, 1);
        r_nwr = 0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            if (bp_wr || busy) r_nwr++;
        end
        chk("R8 no second table", r_nwr, 0);
        chk("R8 bus unchanged", {bp_board, bp_data}, 16'h5123);

        // R9: start in the done cycle is accepted
        mem[8'h80] = 24'h0;
        mem[8'h81] = 24'h006666;
        @(negedge clk);
        launch(8'h80);
        chk("R9 first run duration", r_dur, 2);
        launch(8'h70);
        chk("R9 chained run duration", r_dur, 2);
        chk("R9 chained strobe", r_nwr, 1);
        chk("R9 chained bus", {bp_board, bp_data}, 16'hC777);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        #400000;
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule